// File: doc/BRIEF.md
# NFC-B Card Response Framer

This block turns a card-to-reader response, held in a byte buffer with its CRC already appended, into the serial stream of modulation-control bits that drives a BPSK load modulator. Each elementary time unit (etu) is emitted as four identical output bits. A frame consists of an all-ones phase-reference preamble, a start-of-frame mark, one ten-etu character per byte and an end-of-frame mark.

A start pulse latches the frame length and begins the frame. The framer fetches bytes one at a time from the buffer through a request/valid handshake, always one character ahead of the output, so a buffer that answers within a character time never stalls the stream. The downstream modulator takes one bit per cycle in which `advance` is high while `bitReady` is high. `busy` covers the whole frame, and `done` pulses once the final bit has been taken.

Top module: `nfcb_resp_framer`

## Requirements
- R1: After reset `busy`, `done`, `byteReq` and `bitReady` are all 0.
- R2: Every etu appears as exactly four consecutive identical output bits. Output bit k of a frame belongs to etu k/4.
- R3: A frame opens with 20 etus of 1, which is 80 output bits.
- R4: The preamble is followed by the start-of-frame mark: 10 etus of 0 (40 bits), then 2 etus of 1 (8 bits).
- R5: Each byte becomes a character of 10 etus: a 0 start etu, then the eight data bits least significant first, then a 1 stop etu. Characters follow one another with no gap and are sent in buffer index order 0, 1, 2 and so on.
- R6: The end-of-frame mark comes after the last character: 10 etus of 0, then 2 etus of 1. A frame of length N has 4*(44+10N) output bits in total.
- R7: A frame length of 0 gives preamble, start mark and end mark only. No byte is requested, and `done` still pulses.
- R8: While `bitReady` is high and `advance` is low, `bitOut` holds its value.
- R9: Each byte index from 0 to N-1 is requested exactly once and in increasing order (`byteIdx` is valid while `byteReq` is high). `byteReq` is only high while `busy` is high. If the buffer answers within a few cycles, `bitReady` stays high from the first bit of the frame to the last.
- R10: If a byte has not arrived when its character is due, `bitReady` goes low until the byte arrives. The stream then continues with no bit dropped or inserted.
- R11: A start pulse that arrives while `busy` is high is ignored, together with the `frameLen` value presented with it.
- R12: `done` is a single-cycle pulse. It rises on the clock edge that takes the last end-mark bit, and on that same edge `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a frame (ignored while busy) |
| frameLen | input | LEN_W | Number of bytes in the frame, latched at start |
| byteReq | output | 1 | Framer wants the byte at `byteIdx` |
| byteIdx | output | LEN_W | Index of the requested byte |
| byteValid | input | 1 | `byteData` holds the requested byte this cycle |
| byteData | input | 8 | Requested byte |
| bitOut | output | 1 | Current modulation-control bit |
| bitReady | output | 1 | `bitOut` is valid and may be taken |
| advance | input | 1 | Downstream takes `bitOut` this cycle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The bench sweeps frame lengths 0 to 4 against several `advance` duty patterns. It compares every output bit with a stream it builds arithmetically from the etu index, so a framer that miscounts a mark, reverses the data bit order, repeats a bit three or five times, or leaves a guard etu between characters shows up in the affected region. A zero-length frame catches a design that requests a byte or skips the end mark when there is no character. A slow buffer forces a mid-frame stall, which exposes a design that emits a stale character or drops bits instead of holding `bitReady` low. A second start pulse with a different length, sent in the middle of a frame, catches a design that restarts or re-latches its length. The `done` pulse is timed to the edge after the last taken bit, and a stretched or early pulse is reported.

// File: rtl/nfcb_framer_pkg.sv
package nfcb_framer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SOF_LO,
    PH_SOF_HI,
    PH_WAIT,
    PH_CHAR,
    PH_EOF_LO,
    PH_EOF_HI
  } phase_t;

  typedef struct packed {
    logic newFrame;
    logic loadChar;
    logic shiftChar;
  } dpStrobe_t;

  localparam int CHAR_ETUS = 10;

endpackage

// File: rtl/nfcb_framer_ctrl.sv
module nfcb_framer_ctrl
  import nfcb_framer_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int PRE_ETU    = 20,
  parameter int SOF_LO_ETU = 10,
  parameter int SOF_HI_ETU = 2,
  parameter int EOF_LO_ETU = 10,
  parameter int EOF_HI_ETU = 2,
  parameter int REP        = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             advance,
  input  logic             pfValid,
  input  logic             charBit,
  output dpStrobe_t        strb,
  output logic [LEN_W-1:0] lenLatched,
  output logic             bitOut,
  output logic             bitReady,
  output logic             busy,
  output logic             done
);

  localparam int MAX_A   = (PRE_ETU > CHAR_ETUS) ? PRE_ETU : CHAR_ETUS;
  localparam int MAX_B   = (SOF_LO_ETU > EOF_LO_ETU) ? SOF_LO_ETU : EOF_LO_ETU;
  localparam int ETU_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int ETU_W   = $clog2(ETU_MAX + 1);
  localparam int REP_W   = $clog2(REP + 1);

  phase_t           phase, phaseNext;
  logic [ETU_W-1:0] etuCnt, curLen;
  logic [REP_W-1:0] repCnt;
  logic [LEN_W-1:0] sentCnt;
  logic             stepBit, etuEnd, lastEtu, phaseEnd, moreBytes, doneNext;

  function automatic logic [ETU_W-1:0] phaseEtus(input phase_t p);
    case (p)
      PH_PRE:    return ETU_W'(PRE_ETU);
      PH_SOF_LO: return ETU_W'(SOF_LO_ETU);
      PH_SOF_HI: return ETU_W'(SOF_HI_ETU);
      PH_CHAR:   return ETU_W'(CHAR_ETUS);
      PH_EOF_LO: return ETU_W'(EOF_LO_ETU);
      PH_EOF_HI: return ETU_W'(EOF_HI_ETU);
      default:   return ETU_W'(1);
    endcase
  endfunction

  always_comb begin
    curLen    = phaseEtus(phase);
    bitReady  = (phase != PH_IDLE) && (phase != PH_WAIT);
    busy      = (phase != PH_IDLE);
    stepBit   = bitReady && advance;
    etuEnd    = stepBit && (repCnt == REP_W'(REP - 1));
    lastEtu   = (etuCnt == curLen - ETU_W'(1));
    phaseEnd  = etuEnd && lastEtu;
    moreBytes = (sentCnt < lenLatched);
  end

  always_comb begin
    case (phase)
      PH_SOF_LO, PH_EOF_LO: bitOut = 1'b0;
      PH_CHAR:              bitOut = charBit;
      default:              bitOut = 1'b1;
    endcase
  end

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    doneNext  = 1'b0;
    case (phase)
      PH_IDLE: if (startPulse) begin
        phaseNext     = PH_PRE;
        strb.newFrame = 1'b1;
      end
      PH_PRE:    if (phaseEnd) phaseNext = PH_SOF_LO;
      PH_SOF_LO: if (phaseEnd) phaseNext = PH_SOF_HI;
      PH_SOF_HI, PH_CHAR: begin
        if (phaseEnd) begin
          if (!moreBytes) begin
            phaseNext = PH_EOF_LO;
          end else if (pfValid) begin
            phaseNext     = PH_CHAR;
            strb.loadChar = 1'b1;
          end else begin
            phaseNext = PH_WAIT;
          end
        end else if (etuEnd && phase == PH_CHAR) begin
          strb.shiftChar = 1'b1;
        end
      end
      PH_WAIT: if (pfValid) begin
        phaseNext     = PH_CHAR;
        strb.loadChar = 1'b1;
      end
      PH_EOF_LO: if (phaseEnd) phaseNext = PH_EOF_HI;
      PH_EOF_HI: if (phaseEnd) begin
        phaseNext = PH_IDLE;
        doneNext  = 1'b1;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      etuCnt     <= '0;
      repCnt     <= '0;
      sentCnt    <= '0;
      lenLatched <= '0;
      done       <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= doneNext;
      if (phaseEnd || (phaseNext != phase)) etuCnt <= '0;
      else if (etuEnd)                      etuCnt <= etuCnt + ETU_W'(1);
      if (strb.newFrame) repCnt <= '0;
      else if (stepBit)  repCnt <= (repCnt == REP_W'(REP - 1)) ? '0 : repCnt + REP_W'(1);
      if (strb.newFrame) begin
        sentCnt    <= '0;
        lenLatched <= frameLen;
      end else if (strb.loadChar) begin
        sentCnt <= sentCnt + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/nfcb_framer_dp.sv
module nfcb_framer_dp
  import nfcb_framer_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [LEN_W-1:0] lenLatched,
  input  logic             busy,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             byteReq,
  output logic [LEN_W-1:0] byteIdx,
  output logic             pfValid,
  output logic             charBit
);

  logic [7:0]           pfReg;
  logic [CHAR_ETUS-1:0] shReg;
  logic [LEN_W-1:0]     reqIdx;
  logic                 capture;

  always_comb begin
    byteReq = busy && !pfValid && (reqIdx < lenLatched);
    byteIdx = reqIdx;
    capture = byteReq && byteValid;
    charBit = shReg[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfReg   <= '0;
      pfValid <= 1'b0;
      reqIdx  <= '0;
    end else if (strb.newFrame) begin
      pfValid <= 1'b0;
      reqIdx  <= '0;
    end else if (capture) begin
      pfReg   <= byteData;
      pfValid <= 1'b1;
      reqIdx  <= reqIdx + LEN_W'(1);
    end else if (strb.loadChar) begin
      pfValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               shReg <= '1;
    else if (strb.loadChar)  shReg <= {1'b1, pfReg, 1'b0};
    else if (strb.shiftChar) shReg <= {1'b1, shReg[CHAR_ETUS-1:1]};
  end

endmodule

// File: rtl/nfcb_resp_framer.sv
module nfcb_resp_framer
  import nfcb_framer_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int PRE_ETU    = 20,
  parameter int SOF_LO_ETU = 10,
  parameter int SOF_HI_ETU = 2,
  parameter int EOF_LO_ETU = 10,
  parameter int EOF_HI_ETU = 2,
  parameter int REP        = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] frameLen,
  output logic             byteReq,
  output logic [LEN_W-1:0] byteIdx,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             bitOut,
  output logic             bitReady,
  input  logic             advance,
  output logic             busy,
  output logic             done
);

  dpStrobe_t        strb;
  logic [LEN_W-1:0] lenLatched;
  logic             pfValid, charBit;

  nfcb_framer_ctrl #(
    .LEN_W(LEN_W), .PRE_ETU(PRE_ETU), .SOF_LO_ETU(SOF_LO_ETU),
    .SOF_HI_ETU(SOF_HI_ETU), .EOF_LO_ETU(EOF_LO_ETU),
    .EOF_HI_ETU(EOF_HI_ETU), .REP(REP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .frameLen(frameLen),
    .advance(advance), .pfValid(pfValid), .charBit(charBit), .strb(strb),
    .lenLatched(lenLatched), .bitOut(bitOut), .bitReady(bitReady),
    .busy(busy), .done(done)
  );

  nfcb_framer_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lenLatched(lenLatched),
    .busy(busy), .byteValid(byteValid), .byteData(byteData),
    .byteReq(byteReq), .byteIdx(byteIdx), .pfValid(pfValid),
    .charBit(charBit)
  );

endmodule

// File: rtl/nfcb_resp_framer_chk.sv
module nfcb_resp_framer_chk #(
  parameter int LEN_W     = 8,
  parameter int PRE_BITS  = 80,
  parameter int SOFL_BITS = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [LEN_W-1:0] frameLen,
  input logic             advance,
  input logic             bitOut,
  input logic             bitReady,
  input logic             byteReq,
  input logic             busy,
  input logic             done
);

  logic [15:0] acc;
  logic        lenZ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc  <= '0;
      lenZ <= 1'b0;
    end else if (startPulse && !busy) begin
      acc  <= '0;
      lenZ <= (frameLen == '0);
    end else if (bitReady && advance && acc != 16'hFFFF) begin
      acc <= acc + 16'd1;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    bitReady && !advance |=> $stable(bitOut));

  assert_preamble_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy && bitReady && (acc < 16'(PRE_BITS)) |-> bitOut);

  assert_sof_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy && bitReady && (acc >= 16'(PRE_BITS)) && (acc < 16'(PRE_BITS + SOFL_BITS)) |-> !bitOut);

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy && lenZ |-> !byteReq);

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    byteReq |-> busy);

  assert_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_end_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(bitReady && advance && bitOut));

endmodule

bind nfcb_resp_framer nfcb_resp_framer_chk #(
  .LEN_W(LEN_W), .PRE_BITS(PRE_ETU * REP), .SOFL_BITS(SOF_LO_ETU * REP)
) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .frameLen(frameLen),
  .advance(advance), .bitOut(bitOut), .bitReady(bitReady),
  .byteReq(byteReq), .busy(busy), .done(done)
);

// File: tb/nfcb_resp_framer_bench.sv
`timescale 1ns/1ps
module nfcb_resp_framer_bench;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [LEN_W-1:0] frameLen = '0;
  logic             byteReq;
  logic [LEN_W-1:0] byteIdx;
  logic             byteValid = 1'b0;
  logic [7:0]       byteData = '0;
  logic             bitOut, bitReady;
  logic             advance = 1'b0;
  logic             busy, done;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  nfcb_resp_framer #(.LEN_W(LEN_W)) u_nfcb_resp_framer (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .frameLen(frameLen),
    .byteReq(byteReq), .byteIdx(byteIdx), .byteValid(byteValid),
    .byteData(byteData), .bitOut(bitOut), .bitReady(bitReady),
    .advance(advance), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_);
    end
  endtask

  function automatic int byteVal(input int idx, input int seed);
    return (idx * 37 + seed * 91 + 13) % 256;
  endfunction

  // region: 0 preamble, 1 start mark, 2 characters, 3 end mark
  function automatic int regionOf(input int k, input int len);
    int etu = k / 4;
    if (etu < 20) return 0;
    if (etu < 32) return 1;
    if (etu < 32 + 10 * len) return 2;
    return 3;
  endfunction

  function automatic bit expBit(input int k, input int len, input int seed);
    int etu = k / 4;
    if (etu < 20) return 1'b1;
    if (etu < 30) return 1'b0;
    if (etu < 32) return 1'b1;
    if (etu < 32 + 10 * len) begin
      int c = (etu - 32) / 10;
      int p = (etu - 32) % 10;
      if (p == 0) return 1'b0;
      if (p == 9) return 1'b1;
      return bit'((byteVal(c, seed) >> (p - 1)) & 1);
    end
    if (etu < 42 + 10 * len) return 1'b0;
    return 1'b1;
  endfunction

  // stallExp: 0 no stall check, 1 no stall allowed, 2 stall required
  task automatic runFrame(input int len, input int seed, input int gap,
                          input int lat, input bit midStart, input int stallExp);
    int  total = 4 * (44 + 10 * len);
    int  k = 0;
    int  cyc = 0;
    int  latCnt = 0;
    int  reqCnt = 0;
    int  idxBad = 0;
    int  repBad = 0;
    int  mm[4] = '{default: 0};
    bit  stalled = 0;
    bit  prevBit = 0;
    @(negedge clk);
    frameLen   = LEN_W'(len);
    startPulse = 1'b1;
    advance    = 1'b0;
    while (k < total && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      startPulse = 1'b0;
      frameLen   = LEN_W'(len);
      if (midStart && k == 200) begin
        startPulse = 1'b1;
        frameLen   = LEN_W'(len + 3);
      end
      if (byteValid) begin
        byteValid = 1'b0;
        latCnt    = 0;
      end else if (byteReq) begin
        if (latCnt >= lat) begin
          if (int'(byteIdx) != reqCnt) idxBad++;
          byteData  = 8'(byteVal(int'(byteIdx), seed));
          byteValid = 1'b1;
          reqCnt++;
        end else begin
          latCnt++;
        end
      end
      advance = ((cyc % (gap + 1)) == 0);
      if (busy && !bitReady) stalled = 1;
      if (bitReady && advance) begin
        if (bitOut != expBit(k, len, seed)) mm[regionOf(k, len)]++;
        if ((k % 4) != 0 && bitOut != prevBit) repBad++;
        prevBit = bitOut;
        k++;
      end
    end
    if (cyc >= 30000) chk(1'b0, "watchdog frame", k, total);
    @(negedge clk);
    advance   = 1'b0;
    byteValid = 1'b0;
    chk(done && !busy, "R12 done rises as busy falls", int'(done), 1);
    @(negedge clk);
    chk(!done, "R12 done one cycle", int'(done), 0);
    chk(repBad == 0, "R2 four identical bits per etu", repBad, 0);
    chk(mm[0] == 0, "R3 preamble bits", mm[0], 0);
    chk(mm[1] == 0, "R4 start mark bits", mm[1], 0);
    chk(mm[2] == 0, "R5 character bits", mm[2], 0);
    chk(mm[3] == 0, "R6 end mark bits", mm[3], 0);
    if (len == 0) chk(reqCnt == 0, "R7 no byte request", reqCnt, 0);
    else          chk(reqCnt == len, "R9 request count", reqCnt, len);
    chk(idxBad == 0, "R9 request order", idxBad, 0);
    if (stallExp == 1) chk(!stalled, "R9 no underrun", int'(stalled), 0);
    if (stallExp == 2) chk(stalled, "R10 stall seen", int'(stalled), 1);
    if (midStart) chk(mm[0] + mm[1] + mm[2] + mm[3] == 0 && reqCnt == len,
                      "R11 restart ignored", reqCnt, len);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !byteReq && !bitReady, "R1 reset state",
        {busy, done, byteReq, bitReady}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !bitReady, "R1 idle after reset", {busy, bitReady}, 0);
    for (int len = 0; len <= 4; len++) begin
      for (int gap = 0; gap <= 2; gap++) begin
        runFrame(len, len * 3 + gap, gap, (len + gap) % 3, 1'b0, 1);
      end
    end
    runFrame(16, 7, 0, 1, 1'b0, 1);
    runFrame(3, 9, 0, 60, 1'b0, 2);
    runFrame(4, 11, 1, 2, 1'b1, 1);
    runFrame(0, 2, 3, 0, 1'b0, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule